// File: doc/BRIEF.md
# ATA task-file register decoder

This block is the host-facing register file of an ATA-style storage device running in a True IDE-like I/O mode. The host reaches it through two active-low chip enables, a 4-bit register offset, active-low read and write strobes, and a 16-bit data bus. The chip enables choose the access width. A low enable alone gives a byte cycle on D7-D0. A high enable alone gives a byte cycle on D15-D8 that reaches the odd register just above the given offset. Both enables low give a word cycle. The block decodes each cycle onto 8-bit task-file registers and onto a 16-bit sector-data port. Several registers mean one thing when read and another when written.

The sector-data port sits in front of an internal first-word-fall-through FIFO. Word cycles move one whole word. Byte cycles move the even byte and then the odd byte, and the FIFO moves on only once the pair is complete. A write to the command register hands the command code to the internal controller and raises a busy flag. The controller clears that flag when the command is done. The controller also supplies its own busy, data-request and error information, which the status register reports.

Top module: `ata_taskfile`

## Requirements
- R1: A synchronous reset clears feature, cylinder low, cylinder high, head and device-control to 0, and sets sector count and sector number to 1. It also clears the command-busy flag, so a status read after reset returns 0x40.
- R2: A low-lane byte write takes effect at the first clock edge with the strobe low. Offsets 2, 3, 4, 5 and 6 load sector count, sector number, cylinder low, cylinder high and head. A low-lane byte read of those offsets returns the stored value on D7-D0, with D15-D8 at 0.
- R3: Offset 1 is direction-dependent. A write loads the feature register. A read returns the controller's error byte and never the feature value.
- R4: A write to offset 7 pulses cmdValid for exactly one cycle, with cmdCode holding the written byte, and sets command-busy. A read of offset 7 returns status: bit 7 busy (command-busy OR ctrlBusy), bit 6 ready (the inverse of busy), bit 3 = ctrlDrq, bit 0 = OR of the ctrlError bits, all other bits 0.
- R5: Offset 0xE reads back the same status byte as offset 7. A write to offset 0xE loads device control and issues no command.
- R6: With only the high enable low, an access to offset N reaches the register at offset N|1 on D15-D8, and D7-D0 reads 0. For example, offset 0 gives error/feature, offset 2 gives sector number and offset 8 gives the odd data byte.
- R7: A word cycle at offset 0, 1, 8 or 9 reaches the 16-bit data port. A write pushes busIn into the FIFO for one cycle and leaves the feature register unchanged. A read returns fifoRdData, and fifoPop pulses once in the cycle after the read strobe is released.
- R8: Byte data at offsets 0 and 8 on D7-D0 is the even byte. The odd byte is at offset 9 on D7-D0, or at offset 8 on D15-D8 with only the high enable low. Writing the odd byte after an even byte pushes {odd, even} in that same cycle. Reading the even byte returns fifoRdData[7:0] and reading the odd byte returns fifoRdData[15:8]. The pop happens only after an odd read that follows an even read. An odd byte access with no pending even byte does not move the FIFO.
- R9: A word cycle at the other offsets pairs the register at the even offset (D7-D0) with the register at the odd offset above it (D15-D8). At offset 0xC or 0xD, the high lane is error/feature and the low lane is reserved: it reads 0 and its writes are discarded.
- R10: busOe is high only while rdN is low, wrN is high, at least one enable is low and the decode selects a register. Reserved offsets (0xA, 0xB, 0xF, and byte 0xC) and cycles with no enable low leave it low.
- R11: A strobe held low for many cycles acts once: one push, one pop or one command for each assertion.
- R12: ctrlDone clears command-busy unless a write begins in the same cycle, and ctrlBusy alone also shows busy in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ceLoN | input | 1 | Low-byte chip enable, active low |
| ceHiN | input | 1 | High-byte chip enable, active low |
| regAddr | input | 4 | Register offset |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 16 | Host write data |
| busOut | output | 16 | Host read data |
| busOe | output | 1 | Read data output enable |
| fifoRdData | input | 16 | Head word of the outbound FIFO |
| fifoPop | output | 1 | Advance the outbound FIFO by one word |
| fifoWrData | output | 16 | Word written to the inbound FIFO |
| fifoPush | output | 1 | Push fifoWrData |
| ctrlBusy | input | 1 | Controller busy flag |
| ctrlDrq | input | 1 | Controller data-request flag |
| ctrlDone | input | 1 | Controller finished the current command |
| ctrlError | input | 8 | Controller error byte |
| cmdValid | output | 1 | One-cycle command issue pulse |
| cmdCode | output | 8 | Command byte |
| featureOut | output | 8 | Feature register |
| secCountOut | output | 8 | Sector count register |
| secNumOut | output | 8 | Sector number register |
| cylLoOut | output | 8 | Cylinder low register |
| cylHiOut | output | 8 | Cylinder high register |
| headOut | output | 8 | Card/head select register |
| devCtlOut | output | 8 | Device control register |

## Verification
The assertions assume a host that never lowers rdN and wrN together, and that keeps enables, offset and write data steady from strobe assertion through the cycle in which the strobe rises again. They also assume every strobe stays low for at least one clock. The bench changes inputs only 2 ns after a rising edge, holds each strobe low for one or more whole cycles, and changes the enables only after the strobe has been released for a full cycle. Within those limits the push, pop and command pulses are single-cycle, and push and pop never overlap.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int OFF_W = 4;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA_EVEN,
    SEL_DATA_ODD,
    SEL_DATA_WORD,
    SEL_ERR_FEAT,
    SEL_SEC_CNT,
    SEL_SEC_NUM,
    SEL_CYL_LO,
    SEL_CYL_HI,
    SEL_HEAD,
    SEL_STAT_CMD,
    SEL_ALT_CTL
  } regSel_e;

  // Strobes handed from control to datapath for the current cycle.
  typedef struct packed {
    regSel_e loSel;
    regSel_e hiSel;
    logic    wrStart;
    logic    pushWord;
    logic    pushPair;
    logic    popWord;
    logic    oddOnHigh;
  } tfStrobes_t;

  // Byte-wide meaning of a single offset.
  function automatic regSel_e mapOffset(input logic [OFF_W-1:0] off);
    case (off)
      4'h0, 4'h8: mapOffset = SEL_DATA_EVEN;
      4'h9:       mapOffset = SEL_DATA_ODD;
      4'h1, 4'hD: mapOffset = SEL_ERR_FEAT;
      4'h2:       mapOffset = SEL_SEC_CNT;
      4'h3:       mapOffset = SEL_SEC_NUM;
      4'h4:       mapOffset = SEL_CYL_LO;
      4'h5:       mapOffset = SEL_CYL_HI;
      4'h6:       mapOffset = SEL_HEAD;
      4'h7:       mapOffset = SEL_STAT_CMD;
      4'hE:       mapOffset = SEL_ALT_CTL;
      default:    mapOffset = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ceLoN,
  input  logic             ceHiN,
  input  logic [OFF_W-1:0] regAddr,
  input  logic             rdN,
  input  logic             wrN,
  output tfStrobes_t       strb,
  output logic             busOe
);

  logic rdPrevN, wrPrevN;
  logic evenWrPend, evenRdPend, popArmed;
  logic anyCe, wordCyc, hiOnly;
  logic wrStart, rdStart, rdEnd;
  logic evenSel, oddSel, wordSel, validSel;
  regSel_e loSel, hiSel;

  always_comb begin
    anyCe   = !ceLoN || !ceHiN;
    wordCyc = !ceLoN && !ceHiN;
    hiOnly  = ceLoN && !ceHiN;
    loSel   = SEL_NONE;
    hiSel   = SEL_NONE;
    if (wordCyc) begin
      if (regAddr[2:1] == 2'b00) begin
        loSel = SEL_DATA_WORD;
      end else begin
        loSel = mapOffset({regAddr[OFF_W-1:1], 1'b0});
        hiSel = mapOffset({regAddr[OFF_W-1:1], 1'b1});
      end
    end else if (hiOnly) begin
      hiSel = mapOffset({regAddr[OFF_W-1:1], 1'b1});
    end else if (!ceLoN) begin
      loSel = mapOffset(regAddr);
    end
  end

  assign validSel = (loSel != SEL_NONE) || (hiSel != SEL_NONE);
  assign evenSel  = (loSel == SEL_DATA_EVEN);
  assign oddSel   = (loSel == SEL_DATA_ODD) || (hiSel == SEL_DATA_ODD);
  assign wordSel  = (loSel == SEL_DATA_WORD);

  assign wrStart = !wrN && wrPrevN && rdN && anyCe;
  assign rdStart = !rdN && rdPrevN && wrN && anyCe;
  assign rdEnd   = rdN && !rdPrevN;

  always_comb begin
    strb.loSel     = loSel;
    strb.hiSel     = hiSel;
    strb.wrStart   = wrStart;
    strb.pushWord  = wrStart && wordSel;
    strb.pushPair  = wrStart && oddSel && evenWrPend;
    strb.popWord   = rdEnd && popArmed;
    strb.oddOnHigh = (hiSel == SEL_DATA_ODD);
  end

  assign busOe = !rdN && wrN && validSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPrevN    <= 1'b1;
      wrPrevN    <= 1'b1;
      evenWrPend <= 1'b0;
      evenRdPend <= 1'b0;
      popArmed   <= 1'b0;
    end else begin
      rdPrevN <= rdN;
      wrPrevN <= wrN;
      if (wrStart) begin
        if (evenSel)                evenWrPend <= 1'b1;
        else if (oddSel || wordSel) evenWrPend <= 1'b0;
      end
      if (rdStart) begin
        popArmed <= wordSel || (oddSel && evenRdPend);
        if (evenSel)                evenRdPend <= 1'b1;
        else if (oddSel || wordSel) evenRdPend <= 1'b0;
      end else if (rdEnd) begin
        popArmed <= 1'b0;
      end
    end
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    busOe |-> (!ceLoN || !ceHiN)); // R10

  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
    !((strb.pushWord || strb.pushPair) && strb.popWord)); // R7

endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tfStrobes_t        strb,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  input  logic [DATA_W-1:0] fifoRdData,
  output logic              fifoPop,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              fifoPush,
  input  logic              ctrlBusy,
  input  logic              ctrlDrq,
  input  logic              ctrlDone,
  input  logic [BYTE_W-1:0] ctrlError,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdCode,
  output logic [BYTE_W-1:0] featureOut,
  output logic [BYTE_W-1:0] secCountOut,
  output logic [BYTE_W-1:0] secNumOut,
  output logic [BYTE_W-1:0] cylLoOut,
  output logic [BYTE_W-1:0] cylHiOut,
  output logic [BYTE_W-1:0] headOut,
  output logic [BYTE_W-1:0] devCtlOut
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam logic [BYTE_W-1:0] SEC_RESET = BYTE_W'(1);

  logic [BYTE_W-1:0] featQ, secCntQ, secNumQ, cylLoQ, cylHiQ, headQ, devCtlQ;
  logic [BYTE_W-1:0] evenHoldQ, cmdCodeQ, statusByte, oddByte;
  logic              cmdBusyQ, cmdValidQ, busy;
  regSel_e           laneSel  [LANES];
  logic [BYTE_W-1:0] laneByte [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign laneByte[ln] = busIn[ln*BYTE_W +: BYTE_W];
    assign laneSel[ln]  = (ln == 0) ? strb.loSel : strb.hiSel;
  end

  assign oddByte = strb.oddOnHigh ? laneByte[LANES-1] : laneByte[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      featQ     <= '0;
      secCntQ   <= SEC_RESET;
      secNumQ   <= SEC_RESET;
      cylLoQ    <= '0;
      cylHiQ    <= '0;
      headQ     <= '0;
      devCtlQ   <= '0;
      evenHoldQ <= '0;
      cmdCodeQ  <= '0;
      cmdBusyQ  <= 1'b0;
      cmdValidQ <= 1'b0;
    end else begin
      cmdValidQ <= 1'b0;
      if (ctrlDone) cmdBusyQ <= 1'b0;
      if (strb.wrStart) begin
        for (int ln = 0; ln < LANES; ln++) begin
          case (laneSel[ln])
            SEL_ERR_FEAT:  featQ     <= laneByte[ln];
            SEL_SEC_CNT:   secCntQ   <= laneByte[ln];
            SEL_SEC_NUM:   secNumQ   <= laneByte[ln];
            SEL_CYL_LO:    cylLoQ    <= laneByte[ln];
            SEL_CYL_HI:    cylHiQ    <= laneByte[ln];
            SEL_HEAD:      headQ     <= laneByte[ln];
            SEL_ALT_CTL:   devCtlQ   <= laneByte[ln];
            SEL_DATA_EVEN: evenHoldQ <= laneByte[ln];
            SEL_STAT_CMD: begin
              cmdCodeQ  <= laneByte[ln];
              cmdValidQ <= 1'b1;
              cmdBusyQ  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign busy = cmdBusyQ || ctrlBusy;

  always_comb begin
    statusByte    = '0;
    statusByte[7] = busy;
    statusByte[6] = !busy;
    statusByte[3] = ctrlDrq;
    statusByte[0] = |ctrlError;
  end

  function automatic logic [BYTE_W-1:0] readByte(input regSel_e sel);
    case (sel)
      SEL_ERR_FEAT:               readByte = ctrlError;
      SEL_SEC_CNT:                readByte = secCntQ;
      SEL_SEC_NUM:                readByte = secNumQ;
      SEL_CYL_LO:                 readByte = cylLoQ;
      SEL_CYL_HI:                 readByte = cylHiQ;
      SEL_HEAD:                   readByte = headQ;
      SEL_STAT_CMD, SEL_ALT_CTL:  readByte = statusByte;
      SEL_DATA_EVEN:              readByte = fifoRdData[BYTE_W-1:0];
      SEL_DATA_ODD:               readByte = fifoRdData[DATA_W-1:BYTE_W];
      default:                    readByte = '0;
    endcase
  endfunction

  always_comb begin
    if (strb.loSel == SEL_DATA_WORD) busOut = fifoRdData;
    else busOut = {readByte(strb.hiSel), readByte(strb.loSel)};
  end

  assign fifoPush   = strb.pushWord || strb.pushPair;
  assign fifoWrData = strb.pushWord ? busIn : {oddByte, evenHoldQ};
  assign fifoPop    = strb.popWord;

  assign cmdValid    = cmdValidQ;
  assign cmdCode     = cmdCodeQ;
  assign featureOut  = featQ;
  assign secCountOut = secCntQ;
  assign secNumOut   = secNumQ;
  assign cylLoOut    = cylLoQ;
  assign cylHiOut    = cylHiQ;
  assign headOut     = headQ;
  assign devCtlOut   = devCtlQ;

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifoPush |=> !fifoPush); // R11

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifoPop |=> !fifoPop); // R11

  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> statusByte[7]); // R4

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrlDone && !strb.wrStart) |=> !cmdBusyQ); // R12

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ceLoN,
  input  logic              ceHiN,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] fifoRdData,
  output logic              fifoPop,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              fifoPush,
  input  logic              ctrlBusy,
  input  logic              ctrlDrq,
  input  logic              ctrlDone,
  input  logic [BYTE_W-1:0] ctrlError,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdCode,
  output logic [BYTE_W-1:0] featureOut,
  output logic [BYTE_W-1:0] secCountOut,
  output logic [BYTE_W-1:0] secNumOut,
  output logic [BYTE_W-1:0] cylLoOut,
  output logic [BYTE_W-1:0] cylHiOut,
  output logic [BYTE_W-1:0] headOut,
  output logic [BYTE_W-1:0] devCtlOut
);

  tfStrobes_t strb;

  tf_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ceLoN   (ceLoN),
    .ceHiN   (ceHiN),
    .regAddr (regAddr),
    .rdN     (rdN),
    .wrN     (wrN),
    .strb    (strb),
    .busOe   (busOe)
  );

  tf_datapath #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .busIn       (busIn),
    .busOut      (busOut),
    .fifoRdData  (fifoRdData),
    .fifoPop     (fifoPop),
    .fifoWrData  (fifoWrData),
    .fifoPush    (fifoPush),
    .ctrlBusy    (ctrlBusy),
    .ctrlDrq     (ctrlDrq),
    .ctrlDone    (ctrlDone),
    .ctrlError   (ctrlError),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .featureOut  (featureOut),
    .secCountOut (secCountOut),
    .secNumOut   (secNumOut),
    .cylLoOut    (cylLoOut),
    .cylHiOut    (cylHiOut),
    .headOut     (headOut),
    .devCtlOut   (devCtlOut)
  );

endmodule

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ceLoN = 1'b1, ceHiN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [3:0]  regAddr = '0;
  logic [15:0] busIn = '0;
  logic [15:0] busOut, fifoWrData;
  logic [15:0] headWord = 16'hA1B2;
  logic        busOe, fifoPop, fifoPush, cmdValid;
  logic        ctrlBusy = 1'b0, ctrlDrq = 1'b0, ctrlDone = 1'b0;
  logic [7:0]  ctrlError = '0;
  logic [7:0]  cmdCode, featureOut, secCountOut, secNumOut, cylLoOut, cylHiOut, headOut, devCtlOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] pushQ[$];
  string       pushTagQ[$];
  string       popQ[$];
  logic [7:0]  cmdQ[$];

  always #10 clk = ~clk;

  ata_taskfile uut (
    .clk(clk), .rst(rst), .ceLoN(ceLoN), .ceHiN(ceHiN), .regAddr(regAddr),
    .rdN(rdN), .wrN(wrN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .fifoRdData(headWord), .fifoPop(fifoPop), .fifoWrData(fifoWrData), .fifoPush(fifoPush),
    .ctrlBusy(ctrlBusy), .ctrlDrq(ctrlDrq), .ctrlDone(ctrlDone), .ctrlError(ctrlError),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .featureOut(featureOut),
    .secCountOut(secCountOut), .secNumOut(secNumOut), .cylLoOut(cylLoOut),
    .cylHiOut(cylHiOut), .headOut(headOut), .devCtlOut(devCtlOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic lo, input logic hi, input logic [3:0] a,
                          input logic [15:0] d, input int hold);
    @(posedge clk); #2;
    ceLoN = lo; ceHiN = hi; regAddr = a; busIn = d; wrN = 1'b0;
    repeat (hold) @(posedge clk);
    #2 wrN = 1'b1;
    @(posedge clk); #2;
    ceLoN = 1'b1; ceHiN = 1'b1;
  endtask

  task automatic expectRead(input string req, input logic lo, input logic hi, input logic [3:0] a,
                            input logic [15:0] expD, input logic expOe);
    logic [15:0] d;
    logic oe;
    @(posedge clk); #2;
    ceLoN = lo; ceHiN = hi; regAddr = a; rdN = 1'b0;
    @(negedge clk);
    d = busOut; oe = busOe;
    @(posedge clk); #2 rdN = 1'b1;
    @(posedge clk); #2;
    ceLoN = 1'b1; ceHiN = 1'b1;
    chk(req, {15'd0, oe}, {15'd0, expOe});
    if (expOe) chk(req, d, expD);
  endtask

  // Scoreboard monitor: compares the block's FIFO and command events with the queued expectations.
  always @(negedge clk) begin
    if (!rst) begin
      if (fifoPush) begin
        if (pushQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected push actual %h expected none", fifoWrData);
        end else begin
          logic [15:0] e;
          string t;
          e = pushQ.pop_front();
          t = pushTagQ.pop_front();
          chk(t, fifoWrData, e);
        end
      end
      if (fifoPop) begin
        checks++;
        if (popQ.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected pop actual 1 expected 0");
        end else begin
          void'(popQ.pop_front());
        end
        headWord = headWord + 16'h1111;
      end
      if (cmdValid) begin
        if (cmdQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected command actual %h expected none", cmdCode);
        end else begin
          logic [7:0] c;
          c = cmdQ.pop_front();
          chk("R4 command code", {8'd0, cmdCode}, {8'd0, c});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 secCount", {8'd0, secCountOut}, 16'h0001);
    chk("R1 secNum", {8'd0, secNumOut}, 16'h0001);
    chk("R1 regs zero", {featureOut | cylLoOut | cylHiOut | headOut | devCtlOut, 8'd0}, 16'h0000);
    chk("R1 idle outputs", {13'd0, busOe, cmdValid, fifoPush}, 16'h0000);
    expectRead("R1 status after reset", 1'b0, 1'b1, 4'h7, 16'h0040, 1'b1);

    // R2 low-lane byte registers
    busWrite(1'b0, 1'b1, 4'h2, 16'hFF11, 1);
    busWrite(1'b0, 1'b1, 4'h3, 16'hFF22, 1);
    busWrite(1'b0, 1'b1, 4'h4, 16'hFF33, 1);
    busWrite(1'b0, 1'b1, 4'h5, 16'hFF44, 1);
    busWrite(1'b0, 1'b1, 4'h6, 16'hFFA5, 1);
    chk("R2 byte regs", {secCountOut, secNumOut}, 16'h1122);
    chk("R2 byte regs", {cylLoOut, cylHiOut}, 16'h3344);
    chk("R2 head", {8'd0, headOut}, 16'h00A5);
    expectRead("R2 read cylLo", 1'b0, 1'b1, 4'h4, 16'h0033, 1'b1);

    // R3 error/feature split
    busWrite(1'b0, 1'b1, 4'h1, 16'h005A, 1);
    chk("R3 feature write", {8'd0, featureOut}, 16'h005A);
    ctrlError = 8'h04;
    expectRead("R3 error read", 1'b0, 1'b1, 4'h1, 16'h0004, 1'b1);
    ctrlError = 8'h00;

    // R4 command and status
    ctrlDrq = 1'b1;
    cmdQ.push_back(8'hEC);
    busWrite(1'b0, 1'b1, 4'h7, 16'h00EC, 1);
    expectRead("R4 status busy", 1'b0, 1'b1, 4'h7, 16'h0088, 1'b1);
    @(posedge clk); #2 ctrlDone = 1'b1;
    @(posedge clk); #2 ctrlDone = 1'b0;
    expectRead("R12 done clears busy", 1'b0, 1'b1, 4'h7, 16'h0048, 1'b1);
    ctrlBusy = 1'b1;
    expectRead("R12 ctrlBusy shows", 1'b0, 1'b1, 4'h7, 16'h0088, 1'b1);
    ctrlBusy = 1'b0;

    // R5 alternate status / device control
    busWrite(1'b0, 1'b1, 4'hE, 16'h0006, 1);
    chk("R5 devCtl", {8'd0, devCtlOut}, 16'h0006);
    expectRead("R5 alt status", 1'b0, 1'b1, 4'hE, 16'h0048, 1'b1);
    ctrlDrq = 1'b0;

    // R6 high enable only
    busWrite(1'b1, 1'b0, 4'h2, 16'h7700, 1);
    chk("R6 hi write secNum", {secCountOut, secNumOut}, 16'h1177);
    expectRead("R6 hi read cylHi", 1'b1, 1'b0, 4'h4, 16'h4400, 1'b1);
    busWrite(1'b1, 1'b0, 4'h0, 16'h3C00, 1);
    chk("R6 hi write feature", {8'd0, featureOut}, 16'h003C);
    expectRead("R6 hi read status", 1'b1, 1'b0, 4'h6, 16'h4000, 1'b1);

    // R7 word data port
    pushQ.push_back(16'hBEEF); pushTagQ.push_back("R7 word push off0");
    busWrite(1'b0, 1'b0, 4'h0, 16'hBEEF, 1);
    pushQ.push_back(16'h1234); pushTagQ.push_back("R7 word push off1");
    busWrite(1'b0, 1'b0, 4'h1, 16'h1234, 1);
    chk("R7 off1 word leaves feature", {8'd0, featureOut}, 16'h003C);
    pushQ.push_back(16'hCAFE); pushTagQ.push_back("R7 word push off8");
    busWrite(1'b0, 1'b0, 4'h8, 16'hCAFE, 1);
    popQ.push_back("R7");
    expectRead("R7 word read off0", 1'b0, 1'b0, 4'h0, 16'hA1B2, 1'b1);
    popQ.push_back("R7");
    expectRead("R7 word read off9", 1'b0, 1'b0, 4'h9, 16'hB2C3, 1'b1);

    // R8 byte data pairs
    busWrite(1'b0, 1'b1, 4'h8, 16'h0034, 1);
    pushQ.push_back(16'h1234); pushTagQ.push_back("R8 pair low lanes");
    busWrite(1'b0, 1'b1, 4'h9, 16'h0012, 1);
    busWrite(1'b0, 1'b1, 4'h0, 16'h0078, 1);
    pushQ.push_back(16'h5678); pushTagQ.push_back("R8 pair odd on high");
    busWrite(1'b1, 1'b0, 4'h8, 16'h5600, 1);
    busWrite(1'b0, 1'b1, 4'h9, 16'h0099, 1);
    expectRead("R8 even byte read", 1'b0, 1'b1, 4'h0, 16'h00D4, 1'b1);
    popQ.push_back("R8");
    expectRead("R8 odd byte read high", 1'b1, 1'b0, 4'h8, 16'hC300, 1'b1);
    expectRead("R8 lone odd read", 1'b0, 1'b1, 4'h9, 16'h00D4, 1'b1);

    // R9 word access to byte registers
    busWrite(1'b0, 1'b0, 4'h4, 16'h6655, 1);
    chk("R9 word write cyl", {cylHiOut, cylLoOut}, 16'h6655);
    expectRead("R9 word read sec", 1'b0, 1'b0, 4'h2, 16'h7711, 1'b1);
    busWrite(1'b0, 1'b0, 4'hC, 16'h4B99, 1);
    chk("R9 word at C feature", {8'd0, featureOut}, 16'h004B);
    chk("R9 word at C low discarded", {secCountOut, headOut}, 16'h11A5);
    ctrlError = 8'h21;
    expectRead("R9 word read D", 1'b0, 1'b0, 4'hD, 16'h2100, 1'b1);
    ctrlError = 8'h00;

    // R10 output enable
    expectRead("R10 reserved A", 1'b0, 1'b1, 4'hA, 16'h0000, 1'b0);
    expectRead("R10 reserved byte C", 1'b0, 1'b1, 4'hC, 16'h0000, 1'b0);
    expectRead("R10 hi reserved B", 1'b1, 1'b0, 4'hA, 16'h0000, 1'b0);
    expectRead("R10 no enable", 1'b1, 1'b1, 4'h2, 16'h0000, 1'b0);
    @(negedge clk);
    chk("R10 idle oe", {15'd0, busOe}, 16'h0000);

    // R11 long strobes act once
    pushQ.push_back(16'h0F0F); pushTagQ.push_back("R11 long word push");
    busWrite(1'b0, 1'b0, 4'h8, 16'h0F0F, 5);
    cmdQ.push_back(8'h20);
    busWrite(1'b0, 1'b1, 4'h7, 16'h0020, 4);

    // R1 reset again mid-run
    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset secCount/secNum", {secCountOut, secNumOut}, 16'h0101);
    chk("R1 reset regs", {cylLoOut, headOut}, 16'h0000);
    expectRead("R1 reset clears busy", 1'b0, 1'b1, 4'h7, 16'h0040, 1'b1);

    repeat (3) @(posedge clk);
    chk("R7 push queue drained", 16'(pushQ.size()), 16'd0);
    chk("R8 pop queue drained", 16'(popQ.size()), 16'd0);
    chk("R11 command queue drained", 16'(cmdQ.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule